// File: doc/BRIEF.md
# Configuration Status Interrupt Controller

This block watches twelve configuration status signals and turns the chosen ones into a single interrupt request. Software sets each signal up through a small register bank: it can enable the signal, mask it, pick level or edge detection, and pick the active polarity. The inputs pass through a synchronizer first. The block keeps one pending bit per signal. Software can read the pending bits raw or after masking, and clears them with a write-one end-of-interrupt register.

The register interface is a plain write strobe with a byte address and 32-bit write data. Read data is combinational from the address. Every register uses the same bit for the same signal: bit 0 controller status, 1 configuration complete, 2 initialization complete, 3 checksum error, 4 link-configuration complete, 5 partial-region ready, 6 partial-region error, 7 partial-region complete, 8 configuration-request pin, 9 status pin, 10 configuration-complete pin, 11 power good. A separate register returns the synchronized input levels directly.

Top module: `stsirq_top`

## Requirements
- R1: After reset, every register reads 0, no bit is pending and `irq` is 0.
- R2: Enable (0x830), mask (0x834), type (0x838) and polarity (0x83C) are read/write. Only bits [11:0] are stored. Bits [31:12] read 0. A write takes effect at the next clock edge.
- R3: The port register (0x850) returns the inputs after a two-stage synchronizer. A change applied before edge k is visible after edge k+1. Bits [31:12] read 0.
- R4: When a bit's type is 0, the bit is level-sensitive. It is pending, one edge after the synchronized value, whenever it is enabled and at its active level. Polarity 1 means active high and polarity 0 means active low.
- R5: When a bit's type is 1, the bit is edge-sensitive. It latches on a rising edge when polarity is 1 and on a falling edge when polarity is 0. It stays pending until end-of-interrupt, and an edge in the same cycle as the clear wins.
- R6: Writing 1 to a bit of end-of-interrupt (0x84C) clears that pending bit. A level bit that is still active is pending again one cycle later. Writing 0 to a bit has no effect.
- R7: When an enable bit is 0, that bit is cleared and stays not pending.
- R8: Raw status (0x844) shows all pending bits whatever the mask says. Masked status (0x840) is raw AND NOT mask, so a mask bit of 0 lets the bit through.
- R9: `irq` is the OR of the masked status bits.
- R10: Writes to 0x840, 0x844, 0x850 and to unmapped addresses change nothing. End-of-interrupt and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sts_in | input | 12 | Monitored status signals |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle, per bit:
- a disabled bit never becomes pending;
- a level bit tracks its enabled, active, uncleared state;
- a latched edge bit holds until it is cleared;
- the port's upper bits stay zero;
- the interrupt never fires without a raw pending bit.

Only the bench scenarios can show some other behaviours. These are the exact latency through the synchronizer, the choice of edge direction by polarity, and re-pending after a clear. They also cover writes to read-only addresses and the mask's effect on each view. A bench reference model steps with the clock and compares every register view against the design.

// File: rtl/stsirq_pkg.sv
package stsirq_pkg;
  localparam logic [11:0] OFS_ENABLE = 12'h830;
  localparam logic [11:0] OFS_MASK   = 12'h834;
  localparam logic [11:0] OFS_TYPE   = 12'h838;
  localparam logic [11:0] OFS_POL    = 12'h83C;
  localparam logic [11:0] OFS_MSTAT  = 12'h840;
  localparam logic [11:0] OFS_RSTAT  = 12'h844;
  localparam logic [11:0] OFS_EOI    = 12'h84C;
  localparam logic [11:0] OFS_PORT   = 12'h850;
endpackage

// File: rtl/stsirq_sync.sv
module stsirq_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_comb stg_d[i] = d;
    end else begin : g_next
      always_comb stg_d[i] = stg_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/stsirq_detect.sv
module stsirq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  input  logic en,
  input  logic edge_mode,
  input  logic act_high,
  input  logic clr,
  output logic pend
);
  logic prev_q, pend_q, pend_d;
  logic active, evt;

  always_comb begin
    active = act_high ? s : ~s;
    evt    = act_high ? (s & ~prev_q) : (~s & prev_q);
    if (!en)            pend_d = 1'b0;
    else if (edge_mode) pend_d = evt | (pend_q & ~clr);
    else                pend_d = active & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= s;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pend_q); // R7
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !edge_mode && (s == act_high) && !clr) |=> pend_q); // R4
  AST_LEVEL_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && clr) |=> !pend_q); // R6
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_mode && pend_q && !clr) |=> pend_q); // R5
endmodule

// File: rtl/stsirq_regs.sv
module stsirq_regs
  import stsirq_pkg::*;
#(
  parameter int NBITS = 12,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [11:0]      addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NBITS-1:0] raw,
  input  logic [NBITS-1:0] port,
  output logic [NBITS-1:0] en,
  output logic [NBITS-1:0] mask,
  output logic [NBITS-1:0] typ,
  output logic [NBITS-1:0] pol,
  output logic [NBITS-1:0] eoi,
  output logic [DW-1:0]    rdata
);
  localparam int PAD = DW - NBITS;

  logic [NBITS-1:0] en_q, mask_q, typ_q, pol_q;
  logic             we_en, we_mask, we_typ, we_pol;
  logic [NBITS-1:0] rd_bits;

  always_comb begin
    we_en   = wr && (addr == OFS_ENABLE);
    we_mask = wr && (addr == OFS_MASK);
    we_typ  = wr && (addr == OFS_TYPE);
    we_pol  = wr && (addr == OFS_POL);
    eoi     = (wr && (addr == OFS_EOI)) ? wdata[NBITS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
    end else begin
      if (we_en)   en_q   <= wdata[NBITS-1:0];
      if (we_mask) mask_q <= wdata[NBITS-1:0];
      if (we_typ)  typ_q  <= wdata[NBITS-1:0];
      if (we_pol)  pol_q  <= wdata[NBITS-1:0];
    end
  end

  always_comb begin
    case (addr)
      OFS_ENABLE: rd_bits = en_q;
      OFS_MASK:   rd_bits = mask_q;
      OFS_TYPE:   rd_bits = typ_q;
      OFS_POL:    rd_bits = pol_q;
      OFS_MSTAT:  rd_bits = raw & ~mask_q;
      OFS_RSTAT:  rd_bits = raw;
      OFS_PORT:   rd_bits = port;
      default:    rd_bits = '0;
    endcase
    rdata = {{PAD{1'b0}}, rd_bits};
  end

  assign en   = en_q;
  assign mask = mask_q;
  assign typ  = typ_q;
  assign pol  = pol_q;
endmodule

// File: rtl/stsirq_top.sv
module stsirq_top
  import stsirq_pkg::*;
#(
  parameter int NBITS       = 12,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] sts_in,
  input  logic             bus_wr,
  input  logic [11:0]      bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq
);
  logic [NBITS-1:0] s_sync, en, mask, typ, pol, eoi, raw;

  stsirq_sync #(.WIDTH(NBITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sts_in), .q(s_sync)
  );

  stsirq_regs #(.NBITS(NBITS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .raw(raw), .port(s_sync), .en(en), .mask(mask),
    .typ(typ), .pol(pol), .eoi(eoi), .rdata(bus_rdata)
  );

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    stsirq_detect u_det (
      .clk(clk), .rst_n(rst_n), .s(s_sync[b]), .en(en[b]),
      .edge_mode(typ[b]), .act_high(pol[b]), .clr(eoi[b]), .pend(raw[b])
    );
  end

  assign irq = |(raw & ~mask);

  AST_PORT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_PORT) |-> (bus_rdata[DW-1:NBITS] == '0)); // R3
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw != '0)); // R9
endmodule

// File: tb/sim_stsirq_top.sv
module sim_stsirq_top;
  localparam int NB = 12;

  logic          clk, rst_n, bus_wr, irq;
  logic [NB-1:0] sts_in;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;

  int vectors = 0;
  int errors  = 0;
  logic [NB-1:0] m_en, m_mask, m_typ, m_pol, m_pend, m_prev, m_s, m_s1;

  stsirq_top u0 (
    .clk(clk), .rst_n(rst_n), .sts_in(sts_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h830: return {20'd0, m_en};
      12'h834: return {20'd0, m_mask};
      12'h838: return {20'd0, m_typ};
      12'h83C: return {20'd0, m_pol};
      12'h840: return {20'd0, m_pend & ~m_mask};
      12'h844: return {20'd0, m_pend};
      12'h850: return {20'd0, m_s};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h830, 12'h834, 12'h838, 12'h83C: return "R2";
      12'h840: return "R8";
      12'h844: return "R4/R5";
      12'h850: return "R3";
      default: return "R10";
    endcase
  endfunction

  // one clock: drive at negedge, update model after posedge
  task automatic cyc(input logic [NB-1:0] inv, input logic wr,
                     input logic [11:0] a, input logic [31:0] wd);
    logic [NB-1:0] eoi, act, evt, nxt;
    sts_in = inv; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    eoi = (wr && a == 12'h84C) ? wd[NB-1:0] : '0;
    act = ~(m_s ^ m_pol);
    evt = (m_pol & m_s & ~m_prev) | (~m_pol & ~m_s & m_prev);
    nxt = (m_en & ~m_typ & act & ~eoi) | (m_en & m_typ & (evt | (m_pend & ~eoi)));
    m_pend = nxt; m_prev = m_s; m_s = m_s1; m_s1 = inv;
    if (wr) begin
      case (a)
        12'h830: m_en   = wd[NB-1:0];
        12'h834: m_mask = wd[NB-1:0];
        12'h838: m_typ  = wd[NB-1:0];
        12'h83C: m_pol  = wd[NB-1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk(input logic [11:0] a, input string tag);
    logic [31:0] exp;
    logic        exp_irq;
    bus_addr = a;
    #3;
    exp = model_read(a);
    exp_irq = |(m_pend & ~m_mask);
    vectors++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
    vectors++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL R9 irq actual=%b expected=%b", irq, exp_irq);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [11:0] addrs [9] = '{12'h830, 12'h834, 12'h838, 12'h83C, 12'h840,
                               12'h844, 12'h84C, 12'h850, 12'h900};
    foreach (addrs[i]) chk(addrs[i], tag);
  endtask

  task automatic wr(input logic [NB-1:0] inv, input logic [11:0] a, input logic [31:0] d);
    cyc(inv, 1'b1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; sts_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    {m_en, m_mask, m_typ, m_pol, m_pend, m_prev, m_s, m_s1} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_all("R1");

    // R2: stored width and readback
    wr('0, 12'h834, 32'hFFFF_FFFF); chk(12'h834, "R2");
    wr('0, 12'h834, 32'h0000_0000);
    wr('0, 12'h838, 32'hA5A5_A5A5); chk(12'h838, "R2");
    wr('0, 12'h838, 32'h0);

    // R4: level, active high on bit 0, latency
    wr('0, 12'h83C, 32'h001);
    wr('0, 12'h830, 32'h001);
    cyc(12'h001, 1'b0, 12'h0, 32'h0); chk(12'h850, "R3"); chk(12'h844, "R4");
    cyc(12'h001, 1'b0, 12'h0, 32'h0); chk(12'h850, "R3"); chk(12'h844, "R4");
    cyc(12'h001, 1'b0, 12'h0, 32'h0); chk(12'h844, "R4");
    // R6: clear, re-pend next cycle
    wr(12'h001, 12'h84C, 32'h001); chk(12'h844, "R6");
    cyc(12'h001, 1'b0, 12'h0, 32'h0); chk(12'h844, "R6");
    // R8: masking hides irq but not raw
    wr(12'h001, 12'h834, 32'h001); chk(12'h840, "R8"); chk(12'h844, "R8");
    wr(12'h001, 12'h834, 32'h000);
    // R10: read-only writes ignored
    wr(12'h001, 12'h844, 32'h0); chk(12'h844, "R10");
    wr(12'h001, 12'h900, 32'hFFF); chk_all("R10");
    // R7: disable clears
    wr(12'h001, 12'h830, 32'h000); chk(12'h844, "R7");

    // R5: edge on bit 1 rising, bit 2 falling
    wr('0, 12'h838, 32'h006);
    wr('0, 12'h83C, 32'h002);
    wr('0, 12'h830, 32'h006);
    cyc(12'h006, 1'b0, 12'h0, 32'h0);
    repeat (3) cyc(12'h006, 1'b0, 12'h0, 32'h0);
    chk(12'h844, "R5");
    repeat (4) cyc(12'h000, 1'b0, 12'h0, 32'h0);
    chk(12'h844, "R5");
    wr(12'h000, 12'h84C, 32'h002); chk(12'h844, "R5");
    wr(12'h000, 12'h84C, 32'h004); chk(12'h844, "R6");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] ra;
      logic [11:0] pick [9] = '{12'h830, 12'h834, 12'h838, 12'h83C, 12'h840,
                                12'h844, 12'h84C, 12'h850, 12'h7F0};
      ra = pick[$urandom_range(0, 8)];
      cyc(12'($urandom), ($urandom_range(0, 3) == 0), ra, $urandom);
      ra = pick[$urandom_range(0, 8)];
      chk(ra, tag_of(ra));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule